// File: doc/BRIEF.md
# Command-Level I2C Master

This block is a small I2C bus master that software steers one bus primitive at a time. A single command word selects one of four operations: raise a start condition, raise a stop condition, shift a byte out and capture the target's acknowledge, or shift a byte in and return an acknowledge level of software's choosing. Addressing, transaction framing and retries are all left to software, which simply chains these primitives.

A read-side status word carries a ready flag together with the acknowledge captured by the most recent byte write and the byte gathered by the most recent byte read. While the flag is low a primitive is in flight, the status fields must not be trusted, and any new command word is dropped. The bus pins are open-drain: the block only ever pulls a line low or lets it float. Each bit period is split into four equal quarters of `CLK_DIV` system clocks. A target that holds the clock line low pauses the sequence until the line rises.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the status word reads 0x8000_0000 (ready set in bit 31, acknowledge bit 8 and byte bits 7:0 cleared), and both bus lines are released.
- R2: A write to `cmd_we` while ready is high is accepted. Ready reads low from the next clock until the primitive finishes. The operation code is taken from command bits 13:12.
- R3: Operation code 00 (start) pulls SDA low while SCL is high and ends with SCL held low. This also works as a repeated start after a byte.
- R4: Operation code 01 (stop) lets SDA rise while SCL is high and ends with both lines released.
- R5: Operation code 10 (write) sends command bits 7:0 most significant bit first, one bit per SCL high period. During a byte, SDA changes only while SCL is low.
- R6: During the ninth clock of a write, the master releases SDA and stores the level it sampled in status bit 8. Command bit 8 has no effect on a write.
- R7: Operation code 11 (read) releases SDA for eight clocks and stores the sampled bits, first one as the most significant, in status bits 7:0. Command bits 7:0 have no effect on a read, and status bit 8 is left untouched.
- R8: During the ninth clock of a read, the master drives SDA to the level of command bit 8 (0 = acknowledge, 1 = not acknowledge).
- R9: A command written while ready is low is ignored. The running primitive completes unchanged.
- R10: While the master has released SCL but the line reads low, sequencing stalls. It resumes after the line goes high.
- R11: With no clock stall and `CLK_DIV` of at least 3, ready stays low for 4*`CLK_DIV` clocks on start or stop and for 36*`CLK_DIV` clocks on a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe, one cycle |
| cmd_wdata | input | 32 | Command word: bits 13:12 operation, bit 8 acknowledge to send, bits 7:0 byte to send |
| stat_rdata | output | 32 | Status word: bit 31 ready, bit 8 acknowledge received, bits 7:0 byte received |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_in | input | 1 | Sensed level of the SDA line |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with `CLK_DIV` = 3. This is the smallest divider at which the two-stage input synchroniser still sees a released SCL before the next quarter ends. It keeps a byte at 108 clocks, so exact busy durations, stall extension and many primitives fit in a short run. A behavioural target on the shared wired-AND lines counts start and stop conditions and feeds read bytes and acknowledges. It also holds SCL low mid-byte, which exercises the stall path at that divider.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_STOP  = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_COND,
    SQ_BYTE
  } seq_e;

  localparam int OP_LSB    = 12;
  localparam int ACK_POS   = 8;
  localparam int READY_POS = 31;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;

endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_r [STAGES];

  // open-drain lines float high, so the idle value is all ones
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_r[i] <= '1;
    end else begin
      stage_r[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_r[i] <= stage_r[i-1];
    end
  end

  assign q = stage_r[STAGES-1];

endmodule

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R11: quarter ticks are isolated pulses
  a_r11_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> !tick);

endmodule

// File: rtl/i2c_shreg.sv
module i2c_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= ld_val;
    else if (shift) q <= {q[W-2:0], din};
  end

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int CLK_DIV = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] stat_rdata,
  input  logic        scl_in,
  output logic        scl_drive_low,
  input  logic        sda_in,
  output logic        sda_drive_low
);

  localparam int SLOT_W = $clog2(BYTE_W + 1);
  localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(BYTE_W);
  localparam int PAD_W = WORD_W - 2 - BYTE_W;

  logic          busy;
  seq_e          seq;
  op_e           op_q;
  logic          ack_tx_q;
  logic [1:0]    step;
  logic [SLOT_W-1:0] slot;
  logic          scl_q, sda_q;
  logic          rx_ack;
  logic [BYTE_W-1:0] rx_byte;

  logic          scl_s, sda_s;
  logic          tick, accept, adv, hold, finish;
  logic          sh_load, sh_shift;
  logic [BYTE_W-1:0] sh_q, sh_ld_val;
  op_e           op_in;

  // ---------------- input synchroniser ----------------
  i2c_sync #(.W(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   ({scl_s, sda_s})
  );

  // ---------------- quarter-bit timebase ----------------
  i2c_qtick #(.DIV(CLK_DIV)) u_qtick (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .tick (tick)
  );

  // ---------------- command decode ----------------
  assign op_in  = op_e'(cmd_wdata[OP_LSB+1:OP_LSB]);
  assign accept = cmd_we && !busy;

  // released SCL still reads low: a target is stretching the clock
  assign hold   = !scl_q && !scl_s;
  assign adv    = busy && tick && !hold;
  assign finish = adv && (step == 2'd3) &&
                  ((seq == SQ_COND) || (slot == ACK_SLOT));

  // ---------------- byte shifter ----------------
  assign sh_load   = accept;
  assign sh_ld_val = (op_in == OP_WRITE) ? cmd_wdata[BYTE_W-1:0] : '0;
  assign sh_shift  = adv && (seq == SQ_BYTE) && (step == 2'd2) && (slot != ACK_SLOT);

  i2c_shreg #(.W(BYTE_W)) u_shreg (
    .clk    (clk),
    .rst    (rst),
    .load   (sh_load),
    .ld_val (sh_ld_val),
    .shift  (sh_shift),
    .din    (sda_s),
    .q      (sh_q)
  );

  // level the master pulls SDA to in step 0 of a slot
  logic data_pull, ack_pull;
  assign data_pull = (op_q == OP_WRITE) && !sh_q[BYTE_W-1];
  assign ack_pull  = (op_q == OP_READ) && !ack_tx_q;

  // ---------------- quarter-step sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      seq      <= SQ_IDLE;
      op_q     <= OP_START;
      ack_tx_q <= 1'b0;
      step     <= 2'd0;
      slot     <= '0;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
      rx_ack   <= 1'b0;
      rx_byte  <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      op_q     <= op_in;
      ack_tx_q <= cmd_wdata[ACK_POS];
      step     <= 2'd0;
      slot     <= '0;
      seq      <= (op_in == OP_WRITE || op_in == OP_READ) ? SQ_BYTE : SQ_COND;
    end else if (adv) begin
      step <= step + 2'd1;
      unique case (seq)
        SQ_COND: begin
          if (op_q == OP_START) begin
            unique case (step)
              2'd0: sda_q <= 1'b0;   // free SDA, SCL as it was
              2'd1: scl_q <= 1'b0;   // let SCL rise
              2'd2: sda_q <= 1'b1;   // SDA falls with SCL high
              2'd3: scl_q <= 1'b1;   // park SCL low
            endcase
          end else begin
            unique case (step)
              2'd0: sda_q <= 1'b1;   // SDA low while SCL low
              2'd1: scl_q <= 1'b0;   // let SCL rise
              2'd2: sda_q <= 1'b0;   // SDA rises with SCL high
              2'd3: ;
            endcase
          end
        end
        SQ_BYTE: begin
          unique case (step)
            2'd0: sda_q <= (slot == ACK_SLOT) ? ack_pull : data_pull;
            2'd1: scl_q <= 1'b0;
            2'd2: if (slot == ACK_SLOT && op_q == OP_WRITE) rx_ack <= sda_s;
            2'd3: begin
              scl_q <= 1'b1;
              if (slot != ACK_SLOT) slot <= slot + 1'b1;
            end
          endcase
        end
        default: ;
      endcase
      if (finish) begin
        busy <= 1'b0;
        seq  <= SQ_IDLE;
        if (op_q == OP_READ) rx_byte <= sh_q;
      end
    end
  end

  assign scl_drive_low = scl_q;
  assign sda_drive_low = sda_q;
  assign stat_rdata    = {~busy, {PAD_W{1'b0}}, rx_ack, rx_byte};

  // ---------------- assertions ----------------
  // R2: an accepted command clears ready on the next clock
  a_r2_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !busy) |=> !stat_rdata[READY_POS]);

  // R9: a command offered while busy leaves the running operation alone
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && busy) |=> (busy || $past(finish)) && $stable(op_q));

  // R5: inside a byte, SDA holds while SCL stays released
  a_r5_sda_steady: assert property (@(posedge clk) disable iff (rst)
    (seq == SQ_BYTE && !scl_q && !$past(scl_q)) |-> $stable(sda_q));

  // R6: SDA released in the acknowledge slot of a write
  a_r6_ack_release: assert property (@(posedge clk) disable iff (rst)
    (seq == SQ_BYTE && slot == ACK_SLOT && step != 2'd0 && op_q == OP_WRITE) |-> !sda_q);

  // R10: no progress while a released SCL reads low
  a_r10_scl_wait: assert property (@(posedge clk) disable iff (rst)
    (busy && hold) |=> $stable(step) && $stable(slot));

  // R4: both lines free after a stop
  a_r4_stop_free: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && op_q == OP_STOP) |-> (!scl_q && !sda_q));

  // R3: start ends with both lines pulled low
  a_r3_start_parks: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && op_q == OP_START) |-> (scl_q && sda_q));

endmodule

// File: tb/sim_i2c_cmd_master.sv
`timescale 1ns/1ps
module sim_i2c_cmd_master;

  localparam int D     = 3;
  localparam int T_CND = 4 * D;
  localparam int T_BYT = 36 * D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] stat;
  logic        m_scl_low, m_sda_low;
  logic        s_scl_hold = 1'b0, s_sda_low = 1'b0;
  logic        scl_line, sda_line;

  assign scl_line = !(m_scl_low || s_scl_hold);
  assign sda_line = !(m_sda_low || s_sda_low);

  always #2 clk = ~clk;

  i2c_cmd_master #(.CLK_DIV(D)) u0 (
    .clk           (clk),
    .rst           (rst),
    .cmd_we        (cmd_we),
    .cmd_wdata     (cmd_wdata),
    .stat_rdata    (stat),
    .scl_in        (scl_line),
    .scl_drive_low (m_scl_low),
    .sda_in        (sda_line),
    .sda_drive_low (m_sda_low)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- target model and monitor ----------------
  int          mode = 0;      // 0 none, 1 master writes, 2 master reads
  int          fe = 0, re = 0;
  logic        t_ack = 1'b0;
  logic [7:0]  t_byte = '0;
  logic [7:0]  seen = '0;
  int          n_start = 0, n_stop = 0;
  logic [7:0]  exp_bytes [$];
  logic        exp_acks  [$];

  always @(negedge scl_line) begin
    fe++;
    if (mode == 2) s_sda_low = (fe < 8) ? !t_byte[7-fe] : 1'b0;
    else if (mode == 1) s_sda_low = (fe == 8) ? !t_ack : 1'b0;
  end

  always @(posedge scl_line) begin
    re++;
    if (re <= 8) seen = {seen[6:0], sda_line};
    if (mode == 1 && re == 8) begin
      if (exp_bytes.size() == 0) chk(0, "R5", "unexpected byte on bus", seen, 0);
      else begin
        logic [7:0] e;
        e = exp_bytes.pop_front();
        chk(seen == e, "R5", "byte seen on bus", seen, e);
      end
    end
    if (mode == 2 && re == 9) begin
      if (exp_acks.size() == 0) chk(0, "R8", "unexpected ack slot", sda_line, 0);
      else begin
        logic e;
        e = exp_acks.pop_front();
        chk(sda_line == e, "R8", "ack level driven by master", sda_line, e);
      end
    end
  end

  always @(negedge sda_line) if (scl_line) n_start++;
  always @(posedge sda_line) if (scl_line) n_stop++;

  // ---------------- driver ----------------
  task automatic issue(input logic [1:0] op, input logic [7:0] data,
                       input logic ack, output int cycles);
    @(negedge clk);
    cmd_wdata = (32'(op) << 12) | (32'(ack) << 8) | 32'(data);
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(stat[31] == 1'b0, "R2", "ready after accept", stat[31], 0);
    cycles = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (stat[31]) break;
      cycles++;
    end
  endtask

  task automatic arm_write(input logic [7:0] b, input logic tack);
    fe = 0; re = 0; mode = 1; t_ack = tack; s_sda_low = 1'b0;
    exp_bytes.push_back(b);
  endtask

  task automatic arm_read(input logic [7:0] b, input logic mack);
    fe = 0; re = 0; mode = 2; t_byte = b; s_sda_low = !b[7];
    exp_acks.push_back(mack);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, s0, p0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(stat == 32'h8000_0000, "R1", "status after reset", stat, 32'h8000_0000);
    chk(scl_line && sda_line, "R1", "lines after reset", {scl_line, sda_line}, 2'b11);

    // R3 start from idle, R11 timing
    s0 = n_start; p0 = n_stop;
    issue(2'b00, 8'h00, 1'b0, cyc);
    chk(n_start == s0 + 1, "R3", "start count", n_start, s0 + 1);
    chk(!scl_line && !sda_line, "R3", "lines after start", {scl_line, sda_line}, 2'b00);
    chk(cyc == T_CND, "R11", "start duration", cyc, T_CND);

    // R5/R6 write with target ack, command ack bit set (ignored)
    s0 = n_start; p0 = n_stop;
    arm_write(8'hA5, 1'b0);
    issue(2'b10, 8'hA5, 1'b1, cyc);
    chk(stat[8] == 1'b0, "R6", "ack from target", stat[8], 0);
    chk(cyc == T_BYT, "R11", "byte duration", cyc, T_BYT);
    chk(n_start == s0 && n_stop == p0, "R5", "no condition inside byte",
        n_start + n_stop, s0 + p0);

    // R6 write with target nack, command ack bit clear (ignored)
    arm_write(8'h3C, 1'b1);
    issue(2'b10, 8'h3C, 1'b0, cyc);
    chk(stat[8] == 1'b1, "R6", "nack from target", stat[8], 1);

    // R7/R8 read with ack, data field zero
    s0 = n_start; p0 = n_stop;
    arm_read(8'h96, 1'b0);
    issue(2'b11, 8'h00, 1'b0, cyc);
    chk(stat[7:0] == 8'h96, "R7", "read byte", stat[7:0], 8'h96);
    chk(stat[8] == 1'b1, "R7", "ack bit kept across read", stat[8], 1);
    chk(n_start == s0 && n_stop == p0, "R5", "no condition inside read",
        n_start + n_stop, s0 + p0);

    // R7/R8 read with nack, data field all ones
    arm_read(8'h5A, 1'b1);
    issue(2'b11, 8'hFF, 1'b1, cyc);
    chk(stat[7:0] == 8'h5A, "R7", "read byte with data field set", stat[7:0], 8'h5A);

    // R9 command while busy is ignored
    p0 = n_stop;
    arm_write(8'h81, 1'b0);
    fork
      issue(2'b10, 8'h81, 1'b0, cyc);
      begin
        repeat (20) @(negedge clk);
        cmd_wdata = 32'h0000_1000;
        cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
      end
    join
    chk(cyc == T_BYT, "R9", "busy write length unchanged", cyc, T_BYT);
    chk(n_stop == p0, "R9", "no stop from ignored command", n_stop, p0);
    repeat (10) @(negedge clk);
    chk(stat[31] == 1'b1 && n_stop == p0, "R9", "idle after ignored command",
        {stat[31], 8'(n_stop - p0)}, 9'h100);

    // R3 repeated start after a byte
    s0 = n_start;
    issue(2'b00, 8'h00, 1'b0, cyc);
    chk(n_start == s0 + 1, "R3", "repeated start", n_start, s0 + 1);

    // R10 clock stall by target
    arm_write(8'h42, 1'b0);
    fork
      issue(2'b10, 8'h42, 1'b0, cyc);
      begin
        wait (fe == 3);
        s_scl_hold = 1'b1;
        repeat (40) @(posedge clk);
        s_scl_hold = 1'b0;
      end
    join
    chk(cyc > T_BYT + 30, "R10", "byte stretched by stall", cyc, T_BYT + 30);
    chk(stat[8] == 1'b0, "R10", "ack after stall", stat[8], 0);

    // R4 stop
    mode = 0;
    p0 = n_stop;
    issue(2'b01, 8'h00, 1'b0, cyc);
    chk(n_stop == p0 + 1, "R4", "stop count", n_stop, p0 + 1);
    chk(scl_line && sda_line, "R4", "lines after stop", {scl_line, sda_line}, 2'b11);
    chk(cyc == T_CND, "R11", "stop duration", cyc, T_CND);
    chk(stat[7:0] == 8'h5A, "R7", "read byte retained", stat[7:0], 8'h5A);
    chk(exp_bytes.size() == 0 && exp_acks.size() == 0, "R5", "scoreboard drained",
        exp_bytes.size() + exp_acks.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule